// File: doc/BRIEF.md
# Reset Sequence Generator

This block produces the internal system reset of a chip and drives an open-drain reset pin that other devices on the board share. Three things can start a reset sequence. The first is an asynchronous power-on reset. The second is a single-cycle strobe from the clock monitor, and the third is a single-cycle strobe from the watchdog. Every sequence then runs a fixed number of system clock cycles.

A sequence has four phases:

1. The block pulls the pin low for a drive phase.
2. It lets go of the pin and waits out a settle phase, which covers the pin synchroniser latency plus a configurable extra delay.
3. It runs a wait phase.
4. It checks the synchronised pin level.

If something outside the chip still holds the pin low at the check, the internal reset is stretched until the pin is seen high. A new request that arrives during a sequence restarts it from the drive phase. A cause code records the source of the most recent sequence. The code reads as zero while reset is active and becomes visible once reset has been released.

Top module: `rst_seq_gen`

## Requirements
- R1: While `porN` is low, `sysRst` and `pinPullDn` are 1 and `causeOut` is 00. After `porN` rises, `pinPullDn` drops at the 128th rising edge and `sysRst` drops at the 197th rising edge, both counted from the release. The cause then reads 01 (power-on).
- R2: A request sampled at rising edge E sets `pinPullDn` and `sysRst` to 1 right after E. `pinPullDn` stays 1 until edge E+DRIVE_CYC (E+128 with defaults) and then goes to 0.
- R3: When the pin is high at the check, `sysRst` drops at edge E+DRIVE_CYC+SYNC_STAGES+EXTRA_DLY+WAIT_CYC+1. With the defaults this is E+197.
- R4: When the pin is held low from outside, `sysRst` drops at the later of two edges: E+197, or t+SYNC_STAGES, where t is the first rising edge that sees the pin high.
- R5: A low level on the pin has no effect on the timing if it ends at least SYNC_STAGES edges before the check edge. For example, a low pulse during the wait phase still gives a release at E+197.
- R6: A request during an active sequence restarts the drive phase. `pinPullDn` returns to 1 and the whole timing is measured again from the new request.
- R7: The cause encoding is 01 for power-on, 10 for clock monitor and 11 for watchdog. If both strobes are high in the same cycle, clock monitor wins. The most recent request overwrites the code.
- R8: `causeOut` reads 00 while `sysRst` is 1. Once `sysRst` is 0, it shows the recorded code and holds it until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| cmonReq | input | 1 | Clock monitor reset request strobe |
| wdogReq | input | 1 | Watchdog reset request strobe |
| pinIn | input | 1 | Raw level of the reset pin |
| pinPullDn | output | 1 | Enable of the open-drain pull-down on the reset pin |
| sysRst | output | 1 | Internal system reset, active high |
| causeOut | output | 2 | Code of the source of the last sequence, 00 while in reset |

## Verification
Every result is timed from the rising edge E that samples the request. `pinPullDn` and `sysRst` are due just after E, and the masked cause reads 00 at that point. The pin release is due at E+128. The reset release is due at E+197, or at two edges after the first edge that sees the pin high, whichever comes later. The bench changes inputs on falling edges and samples on every falling edge after E. It records the exact edge index at which each output first falls and compares that index with the value computed from these formulas. This includes the stretch boundary on each side, where the external release lands exactly one cycle before or one cycle after the window closes.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DRIVE  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_WAIT   = 3'd3,
    ST_CHECK  = 3'd4
  } seqState_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_POR  = 2'b01,
    CAUSE_CMON = 2'b10,
    CAUSE_WDOG = 2'b11
  } rstCause_t;

  typedef enum logic [1:0] {
    LIM_DRIVE  = 2'd0,
    LIM_SETTLE = 2'd1,
    LIM_WAIT   = 2'd2,
    LIM_NONE   = 2'd3
  } limSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    cntClr;
    logic    cntEn;
    limSel_t limSel;
    logic    drivePin;
    logic    holdRst;
    logic    latchCause;
  } seqStrobe_t;

endpackage

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
  import rsg_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       cmonReq,
  input  logic       wdogReq,
  input  logic       phaseEnd,
  input  logic       pinHigh,
  output seqStrobe_t strb
);

  seqState_t stateQ, stateD;
  logic      anyReq;

  assign anyReq = cmonReq | wdogReq;

  always_comb begin
    stateD = stateQ;
    if (anyReq) begin
      stateD = ST_DRIVE;
    end else begin
      case (stateQ)
        ST_IDLE:   stateD = ST_IDLE;
        ST_DRIVE:  if (phaseEnd) stateD = ST_SETTLE;
        ST_SETTLE: if (phaseEnd) stateD = ST_WAIT;
        ST_WAIT:   if (phaseEnd) stateD = ST_CHECK;
        ST_CHECK:  if (pinHigh)  stateD = ST_IDLE;
        default:   stateD = ST_DRIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) stateQ <= ST_DRIVE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.cntClr     = anyReq || (stateD != stateQ);
    strb.cntEn      = (stateQ == ST_DRIVE) || (stateQ == ST_SETTLE) || (stateQ == ST_WAIT);
    strb.drivePin   = (stateD == ST_DRIVE);
    strb.holdRst    = (stateD != ST_IDLE);
    strb.latchCause = anyReq;
    case (stateQ)
      ST_DRIVE:  strb.limSel = LIM_DRIVE;
      ST_SETTLE: strb.limSel = LIM_SETTLE;
      ST_WAIT:   strb.limSel = LIM_WAIT;
      default:   strb.limSel = LIM_NONE;
    endcase
  end

  // R6: any request forces the drive phase on the next cycle
  p_req_restart_r6: assert property (@(posedge clk) disable iff (!porN)
    anyReq |=> (stateQ == ST_DRIVE));

  // R4: the check phase is only left once the synchronised pin is high
  p_hold_while_low_r4: assert property (@(posedge clk) disable iff (!porN)
    (stateQ == ST_CHECK && !pinHigh && !anyReq) |=> (stateQ == ST_CHECK));

  // R3: the wait phase is only entered from the settle phase
  p_phase_order_r3: assert property (@(posedge clk) disable iff (!porN)
    (stateQ == ST_WAIT && $past(stateQ) != ST_WAIT) |-> ($past(stateQ) == ST_SETTLE));

endmodule

// File: rtl/rsg_datapath.sv
module rsg_datapath
  import rsg_pkg::*;
#(
  parameter int DRIVE_CYC   = 128,
  parameter int SETTLE_CYC  = 4,
  parameter int WAIT_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       cmonReq,
  input  logic       wdogReq,
  input  logic       pinIn,
  input  seqStrobe_t strb,
  output logic       phaseEnd,
  output logic       pinHigh,
  output logic       pinPullDn,
  output logic       sysRst,
  output logic [1:0] causeOut
);

  localparam int MAX_AB  = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
  localparam int MAX_CYC = (MAX_AB > SETTLE_CYC) ? MAX_AB : SETTLE_CYC;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] LIM_DRV = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_SET = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_WT  = CNT_W'(WAIT_CYC - 1);

  logic [CNT_W-1:0]       cntQ;
  logic [CNT_W-1:0]       limVal;
  logic [SYNC_STAGES-1:0] syncQ;
  rstCause_t              causeQ;
  logic                   anyReq;

  assign anyReq = cmonReq | wdogReq;

  // pin synchroniser, depth picked by parameter
  if (SYNC_STAGES == 1) begin : g_sync_one
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) syncQ <= '0;
      else       syncQ <= pinIn;
    end
  end else begin : g_sync_chain
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
    end
  end

  assign pinHigh = syncQ[SYNC_STAGES-1];

  // one counter shared by all timed phases
  always_comb begin
    case (strb.limSel)
      LIM_DRIVE:  limVal = LIM_DRV;
      LIM_SETTLE: limVal = LIM_SET;
      LIM_WAIT:   limVal = LIM_WT;
      default:    limVal = '1;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)             cntQ <= '0;
    else if (strb.cntClr)  cntQ <= '0;
    else if (strb.cntEn)   cntQ <= cntQ + 1'b1;
  end

  assign phaseEnd = (cntQ == limVal);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pinPullDn <= 1'b1;
      sysRst    <= 1'b1;
    end else begin
      pinPullDn <= strb.drivePin;
      sysRst    <= strb.holdRst;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                causeQ <= CAUSE_POR;
    else if (strb.latchCause) causeQ <= cmonReq ? CAUSE_CMON : CAUSE_WDOG;
  end

  assign causeOut = sysRst ? CAUSE_NONE : causeQ;

  // R2: counter never runs past the limit of the active phase
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!porN)
    strb.cntEn |-> (cntQ <= limVal));

  // R1: pin is only pulled while internal reset is active
  p_pin_in_reset_r1: assert property (@(posedge clk) disable iff (!porN)
    pinPullDn |-> sysRst);

  // R7: a released reset always reports a real cause
  p_cause_known_r7: assert property (@(posedge clk) disable iff (!porN)
    $fell(sysRst) |-> (causeOut != CAUSE_NONE));

  // R8: outside reset the cause holds until a new request
  p_cause_hold_r8: assert property (@(posedge clk) disable iff (!porN)
    (!sysRst && !anyReq) |=> $stable(causeOut));

endmodule

// File: rtl/rst_seq_gen.sv
module rst_seq_gen
  import rsg_pkg::*;
#(
  parameter int DRIVE_CYC   = 128,
  parameter int EXTRA_DLY   = 2,
  parameter int WAIT_CYC    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       cmonReq,
  input  logic       wdogReq,
  input  logic       pinIn,
  output logic       pinPullDn,
  output logic       sysRst,
  output logic [1:0] causeOut
);

  localparam int SETTLE_CYC = SYNC_STAGES + EXTRA_DLY;

  seqStrobe_t strb;
  logic       phaseEnd;
  logic       pinHigh;

  rsg_ctrl u_ctrl (
    .clk      (clk),
    .porN     (porN),
    .cmonReq  (cmonReq),
    .wdogReq  (wdogReq),
    .phaseEnd (phaseEnd),
    .pinHigh  (pinHigh),
    .strb     (strb)
  );

  rsg_datapath #(
    .DRIVE_CYC   (DRIVE_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .WAIT_CYC    (WAIT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .porN      (porN),
    .cmonReq   (cmonReq),
    .wdogReq   (wdogReq),
    .pinIn     (pinIn),
    .strb      (strb),
    .phaseEnd  (phaseEnd),
    .pinHigh   (pinHigh),
    .pinPullDn (pinPullDn),
    .sysRst    (sysRst),
    .causeOut  (causeOut)
  );

endmodule

// File: tb/rst_seq_gen_tb.sv
module rst_seq_gen_tb;

  localparam int NVEC    = 8;
  localparam int PIN_REL = 128;
  localparam int RST_REL = 197;

  // vector table: request bits, external hold window [from,to), expected cause, expected release edge
  localparam int V_CMON[NVEC]  = '{1, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_WDOG[NVEC]  = '{0, 1, 1, 1, 0, 1, 0, 1};
  localparam int V_HFROM[NVEC] = '{0, 0, 0, 0, 0, 0, 140, 100};
  localparam int V_HTO[NVEC]   = '{0, 0, 0, 194, 195, 300, 180, 196};
  localparam int V_CAUSE[NVEC] = '{2, 3, 2, 3, 2, 3, 2, 3};
  localparam int V_REL[NVEC]   = '{197, 197, 197, 197, 198, 303, 197, 199};

  logic       clk = 1'b0;
  logic       porN, cmonReq, wdogReq, extHold;
  logic       pinIn;
  logic       pinPullDn, sysRst;
  logic [1:0] causeOut;
  int         nChecks = 0;
  int         nFail   = 0;

  always #2 clk = ~clk;

  assign pinIn = !(pinPullDn || extHold);

  rst_seq_gen u_dut (
    .clk       (clk),
    .porN      (porN),
    .cmonReq   (cmonReq),
    .wdogReq   (wdogReq),
    .pinIn     (pinIn),
    .pinPullDn (pinPullDn),
    .sysRst    (sysRst),
    .causeOut  (causeOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runSeq(input bit c, input bit w, input int hFrom, input int hTo,
                        output int pinFall, output int rstFall, output int causeAtStart);
    @(negedge clk);
    cmonReq = c;
    wdogReq = w;
    @(negedge clk);
    cmonReq = 1'b0;
    wdogReq = 1'b0;
    causeAtStart = int'(causeOut);
    pinFall = -1;
    rstFall = -1;
    for (int k = 0; k < 1000 && rstFall < 0; k++) begin
      if (k > 0) @(negedge clk);
      if (pinFall < 0 && !pinPullDn) pinFall = k;
      if (!sysRst) rstFall = k;
      extHold = (k >= hFrom) && (k < hTo);
    end
    extHold = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int pinFall, rstFall, causeStart;
    bit pinSeen;
    logic [1:0] causeHeld;
    porN = 1'b0;
    cmonReq = 1'b0;
    wdogReq = 1'b0;
    extHold = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state while power-on reset is low
    check(sysRst == 1'b1, "R1 sysRst in POR", int'(sysRst), 1);
    check(pinPullDn == 1'b1, "R1 pinPullDn in POR", int'(pinPullDn), 1);
    check(causeOut == 2'b00, "R1 cause masked in POR", int'(causeOut), 0);

    // R1: timing after power-on release
    porN = 1'b1;
    pinFall = -1;
    rstFall = -1;
    for (int k = 1; k < 1000 && rstFall < 0; k++) begin
      @(negedge clk);
      if (pinFall < 0 && !pinPullDn) pinFall = k;
      if (!sysRst) rstFall = k;
    end
    check(pinFall == PIN_REL, "R1 pin release edge", pinFall, PIN_REL);
    check(rstFall == RST_REL, "R1 reset release edge", rstFall, RST_REL);
    check(causeOut == 2'b01, "R1 power-on cause", int'(causeOut), 1);

    // vector table walk: R2 R3 R4 R5 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      runSeq(V_CMON[v] != 0, V_WDOG[v] != 0, V_HFROM[v], V_HTO[v], pinFall, rstFall, causeStart);
      check(pinFall == PIN_REL, $sformatf("R2 pin release vec%0d", v), pinFall, PIN_REL);
      check(rstFall == V_REL[v], $sformatf("R3/R4/R5 reset release vec%0d", v), rstFall, V_REL[v]);
      check(causeStart == 0, $sformatf("R8 cause masked vec%0d", v), causeStart, 0);
      check(int'(causeOut) == V_CAUSE[v], $sformatf("R7 cause vec%0d", v), int'(causeOut), V_CAUSE[v]);
    end

    // R8: cause holds while idle
    causeHeld = causeOut;
    repeat (20) @(negedge clk);
    check(causeOut == causeHeld, "R8 cause held idle", int'(causeOut), int'(causeHeld));

    // R6: restart from the wait phase with a different source
    @(negedge clk);
    cmonReq = 1'b1;
    @(negedge clk);
    cmonReq = 1'b0;
    repeat (150) @(negedge clk);
    check(pinPullDn == 1'b0, "R6 pin released before restart", int'(pinPullDn), 0);
    check(sysRst == 1'b1, "R6 still in reset before restart", int'(sysRst), 1);
    check(causeOut == 2'b00, "R8 cause masked mid sequence", int'(causeOut), 0);
    runSeq(1'b0, 1'b1, 0, 0, pinFall, rstFall, causeStart);
    check(pinFall == PIN_REL, "R6 pin drive after restart", pinFall, PIN_REL);
    check(rstFall == RST_REL, "R6 release after restart", rstFall, RST_REL);
    check(causeOut == 2'b11, "R6 R7 latest cause wins", int'(causeOut), 3);

    // R6: restart during the drive phase keeps the pin low continuously
    @(negedge clk);
    wdogReq = 1'b1;
    @(negedge clk);
    wdogReq = 1'b0;
    repeat (60) @(negedge clk);
    runSeq(1'b1, 1'b0, 0, 0, pinFall, rstFall, causeStart);
    check(pinFall == PIN_REL, "R6 drive restart pin", pinFall, PIN_REL);
    check(rstFall == RST_REL, "R6 drive restart release", rstFall, RST_REL);
    check(causeOut == 2'b10, "R7 clock monitor cause", int'(causeOut), 2);

    // R2: a request in idle raises both outputs right after the sampling edge
    @(negedge clk);
    wdogReq = 1'b1;
    @(negedge clk);
    wdogReq = 1'b0;
    pinSeen = pinPullDn && sysRst;
    check(pinSeen, "R2 outputs high after request edge", int'(pinSeen), 1);
    repeat (300) @(negedge clk);
    check(sysRst == 1'b0, "R3 reset ends", int'(sysRst), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule